// File: doc/BRIEF.md
# GPIO Event Detector with Grouped Interrupts

This block watches 54 general-purpose input pins and records, per pin, whether a selected kind of event has occurred. Software chooses the event kinds per pin through six enable registers: synchronous rising edge, synchronous falling edge, high level, low level, and early rising and falling edges. Each kind has two 32-bit bank words, bank 0 for pins 0 to 31 and bank 1 for pins 32 to 53. A detected event sets a sticky status bit. Software clears that bit by writing a one to it.

The status bits drive three interrupt lines. Each line covers one fixed, contiguous range of pins. The middle range crosses the bank boundary, so a handler for that line has to read both status words. Pin inputs pass through a two-flop synchronizer first. The early edge kinds look at the first synchronizer stage and the synchronized output, so they report one cycle sooner than the synchronous edge kinds.

Register access uses a simple single-cycle bus. A write is taken on the clock edge where `bus_we` is high. A read is combinational from the address.

Top module: `pin_event_irq`

## Requirements
- R1: After reset, every enable register and both status words read as zero and all three interrupt lines are low.
- R2: Enable words are read/write at these byte addresses, bank 0 first and bank 1 at +4: rise 0x4C, fall 0x58, high 0x64, low 0x70, early-rise 0x7C, early-fall 0x88. In bank 1, bits 22 to 31 always read zero.
- R3: When a pin's rise enable is set and the pin goes from 0 to 1, its status bit (status words at 0x40 and 0x44) sets on the third rising clock edge after the change. It is still clear after the second.
- R4: When a pin's fall enable is set and the pin goes from 1 to 0, its status bit sets. A rising edge on a pin with only fall enabled sets nothing.
- R5: When both the rise and fall enables are set for a pin, both edge directions set its status bit.
- R6: With the high enable set, the status bit is set again on every cycle the synchronized pin is 1, so a clear written while the level holds leaves the bit at 1.
- R7: With the low enable set, a synchronized level of 0 sets the status bit.
- R8: With the early-rise or early-fall enable set, the matching edge sets the status bit on the second rising clock edge after the pin changes.
- R9: Writing a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: A status bit stays set after its enable is cleared, until it is cleared by a write.
- R11: If an event and a clear of the same status bit fall on the same clock edge, the bit ends up set.
- R12: irq_o[0] is the OR of the status bits of pins 0 to 27. irq_o[1] covers pins 28 to 45, which are bank 0 bits 28 to 31 and bank 1 bits 0 to 13. irq_o[2] covers pins 46 to 53, which are bank 1 bits 14 to 21.
- R13: A pin with no enable set never sets its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 54 | Raw pin levels, asynchronous to clk |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 3 | Grouped interrupt lines |

## Verification
Results are due at these edges, counting the rising edges after a pin change made at a falling edge:
- An early edge reaches status on the second edge, because it compares synchronizer stages one and two.
- A synchronous edge or a level reaches status on the third edge.
- Interrupt lines follow status with no added delay.
- A register write takes effect on the edge that samples the strobe.

The bench drives every input at a falling edge and samples half a cycle after the edge where the result is due. It also checks for the absence of the synchronous result one cycle earlier. The collision case is timed so that the clear write and the falling-edge detection land on the same edge.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
    localparam int PIN_COUNT  = 54;
    localparam int BANK_W     = 32;
    localparam int BANK_COUNT = (PIN_COUNT + BANK_W - 1) / BANK_W;
    localparam int PAD_W      = BANK_COUNT * BANK_W;
    localparam int ADDR_W     = 8;
    localparam int IRQ_COUNT  = 3;

    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_RISE  = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_FALL  = 8'h58;
    localparam logic [ADDR_W-1:0] OFF_HIGH  = 8'h64;
    localparam logic [ADDR_W-1:0] OFF_LOW   = 8'h70;
    localparam logic [ADDR_W-1:0] OFF_ARISE = 8'h7C;
    localparam logic [ADDR_W-1:0] OFF_AFALL = 8'h88;

    typedef logic [PIN_COUNT-1:0] pin_vec_t;

    typedef struct packed {
        pin_vec_t rise;
        pin_vec_t fall;
        pin_vec_t high;
        pin_vec_t low;
        pin_vec_t arise;
        pin_vec_t afall;
    } det_en_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync
    import gpio_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_vec_t pin_i,
    output pin_vec_t near_o,
    output pin_vec_t lvl_o,
    output pin_vec_t prev_o
);
    typedef struct packed {
        pin_vec_t s1;
        pin_vec_t s2;
        pin_vec_t s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = pin_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign near_o = sync_q.s1;
    assign lvl_o  = sync_q.s2;
    assign prev_o = sync_q.s3;
endmodule

// File: rtl/evt_detect.sv
module evt_detect
    import gpio_evt_pkg::*;
(
    input  det_en_t  en_i,
    input  pin_vec_t near_i,
    input  pin_vec_t lvl_i,
    input  pin_vec_t prev_i,
    output pin_vec_t set_o
);
    pin_vec_t sync_rise, sync_fall, early_rise, early_fall;

    always_comb begin
        sync_rise  =  lvl_i  & ~prev_i;
        sync_fall  = ~lvl_i  &  prev_i;
        early_rise =  near_i & ~lvl_i;
        early_fall = ~near_i &  lvl_i;
        set_o = (en_i.rise  & sync_rise)
              | (en_i.fall  & sync_fall)
              | (en_i.high  & lvl_i)
              | (en_i.low   & ~lvl_i)
              | (en_i.arise & early_rise)
              | (en_i.afall & early_fall);
    end
endmodule

// File: rtl/evt_regs.sv
module evt_regs
    import gpio_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  pin_vec_t          evt_set_i,
    output det_en_t           en_o,
    output pin_vec_t          stat_o,
    output logic [31:0]       rdata_o
);
    typedef struct packed {
        det_en_t  en;
        pin_vec_t stat;
    } regs_t;

    regs_t    r_d, r_q;
    pin_vec_t clr_w;

    function automatic logic is_hit(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] base, input int b);
        return a == (base + ADDR_W'(4 * b));
    endfunction

    function automatic pin_vec_t put_word(input pin_vec_t v, input int b,
                                          input logic [31:0] w);
        logic [PAD_W-1:0] t;
        t = PAD_W'(v);
        t[b*BANK_W +: BANK_W] = w;
        return t[PIN_COUNT-1:0];
    endfunction

    function automatic logic [31:0] get_word(input pin_vec_t v, input int b);
        logic [PAD_W-1:0] t;
        t = PAD_W'(v);
        return t[b*BANK_W +: BANK_W];
    endfunction

    always_comb begin
        r_d   = r_q;
        clr_w = '0;
        if (bus_we) begin
            for (int b = 0; b < BANK_COUNT; b++) begin
                if (is_hit(bus_addr, OFF_STAT, b))  clr_w       = put_word(clr_w, b, bus_wdata);
                if (is_hit(bus_addr, OFF_RISE, b))  r_d.en.rise  = put_word(r_q.en.rise, b, bus_wdata);
                if (is_hit(bus_addr, OFF_FALL, b))  r_d.en.fall  = put_word(r_q.en.fall, b, bus_wdata);
                if (is_hit(bus_addr, OFF_HIGH, b))  r_d.en.high  = put_word(r_q.en.high, b, bus_wdata);
                if (is_hit(bus_addr, OFF_LOW, b))   r_d.en.low   = put_word(r_q.en.low, b, bus_wdata);
                if (is_hit(bus_addr, OFF_ARISE, b)) r_d.en.arise = put_word(r_q.en.arise, b, bus_wdata);
                if (is_hit(bus_addr, OFF_AFALL, b)) r_d.en.afall = put_word(r_q.en.afall, b, bus_wdata);
            end
        end
        // a new event takes priority over a clear on the same edge
        r_d.stat = (r_q.stat & ~clr_w) | evt_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < BANK_COUNT; b++) begin
            if (is_hit(bus_addr, OFF_STAT, b))  rdata_o = get_word(r_q.stat, b);
            if (is_hit(bus_addr, OFF_RISE, b))  rdata_o = get_word(r_q.en.rise, b);
            if (is_hit(bus_addr, OFF_FALL, b))  rdata_o = get_word(r_q.en.fall, b);
            if (is_hit(bus_addr, OFF_HIGH, b))  rdata_o = get_word(r_q.en.high, b);
            if (is_hit(bus_addr, OFF_LOW, b))   rdata_o = get_word(r_q.en.low, b);
            if (is_hit(bus_addr, OFF_ARISE, b)) rdata_o = get_word(r_q.en.arise, b);
            if (is_hit(bus_addr, OFF_AFALL, b)) rdata_o = get_word(r_q.en.afall, b);
        end
    end

    assign en_o   = r_q.en;
    assign stat_o = r_q.stat;

    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.stat & ~clr_w) != '0) |=>
            ((r_q.stat & $past(r_q.stat & ~clr_w)) == $past(r_q.stat & ~clr_w)));

    // R11
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_set_i & clr_w) != '0) |=>
            ((r_q.stat & $past(evt_set_i & clr_w)) == $past(evt_set_i & clr_w)));
endmodule

// File: rtl/irq_group.sv
module irq_group
    import gpio_evt_pkg::*;
#(
    parameter int LAST0 = 27,
    parameter int LAST1 = 45
) (
    input  pin_vec_t             stat_i,
    output logic [IRQ_COUNT-1:0] irq_o
);
    for (genvar g = 0; g < IRQ_COUNT; g++) begin : g_line
        localparam int LO = (g == 0) ? 0 : (g == 1) ? LAST0 + 1 : LAST1 + 1;
        localparam int HI = (g == 0) ? LAST0 : (g == 1) ? LAST1 : PIN_COUNT - 1;
        assign irq_o[g] = |stat_i[HI:LO];
    end
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
    import gpio_evt_pkg::*;
#(
    parameter int IRQ0_LAST = 27,
    parameter int IRQ1_LAST = 45
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pin_i,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [IRQ_COUNT-1:0] irq_o
);
    pin_vec_t near, lvl, prev, evt_set, stat, any_en;
    det_en_t  en;

    pin_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .near_o (near),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    evt_detect u_det (
        .en_i   (en),
        .near_i (near),
        .lvl_i  (lvl),
        .prev_i (prev),
        .set_o  (evt_set)
    );

    evt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .evt_set_i (evt_set),
        .en_o      (en),
        .stat_o    (stat),
        .rdata_o   (bus_rdata)
    );

    irq_group #(.LAST0(IRQ0_LAST), .LAST1(IRQ1_LAST)) u_irq (
        .stat_i (stat),
        .irq_o  (irq_o)
    );

    assign any_en = en.rise | en.fall | en.high | en.low | en.arise | en.afall;

    // R13
    no_unenabled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set & ~any_en) == '0);

    // R6
    level_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en.high & lvl) != '0) |=>
            ((stat & $past(en.high & lvl)) == $past(en.high & lvl)));

    // R12
    irq_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irq_o & $past(irq_o)) != '0) |->
            $past(bus_we && (bus_addr == OFF_STAT || bus_addr == OFF_STAT + 8'h04)));
endmodule

// File: tb/tb_pin_event_irq.sv
module tb_pin_event_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [53:0] pins = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_event_irq dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clear_all();
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
    endtask

    initial begin
        logic [31:0] v0, v1;
        logic [7:0] bases [6] = '{8'h4C, 8'h58, 8'h64, 8'h70, 8'h7C, 8'h88};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int k = 0; k < 6; k++) begin
            rd(bases[k], v0); check("R1 enable bank0", v0, 0);
            rd(bases[k] + 8'h04, v1); check("R1 enable bank1", v1, 0);
        end
        rd(8'h40, v0); check("R1 status0", v0, 0);
        rd(8'h44, v1); check("R1 status1", v1, 0);
        check("R1 irq", 32'(irq), 0);

        // R2 read back, unused bank1 bits read zero
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            wr(bases[k], 32'hA5C3_5A3C ^ 32'(k));
            wr(bases[k] + 8'h04, 32'hFFFF_FFFF);
            rd(bases[k], v0); check("R2 bank0 readback", v0, 32'hA5C3_5A3C ^ 32'(k));
            rd(bases[k] + 8'h04, v1); check("R2 bank1 width", v1, 32'h003F_FFFF);
            @(negedge clk);
            wr(bases[k], 0);
            wr(bases[k] + 8'h04, 0);
        end
        pins = '1;
        repeat (4) @(negedge clk);
        pins = '0;
        repeat (4) @(negedge clk);
        clear_all();
        rd(8'h40, v0); check("R2 cleanup status0", v0, 0);

        // R3 / R12 sweep over every pin with rise enabled
        wr(8'h4C, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        for (int p = 0; p < 54; p++) begin
            logic [31:0] e0, e1;
            logic [2:0] ei;
            e0 = (p < 32) ? (32'd1 << p) : 32'd0;
            e1 = (p >= 32) ? (32'd1 << (p - 32)) : 32'd0;
            ei = (p <= 27) ? 3'b001 : (p <= 45) ? 3'b010 : 3'b100;
            pins[p] = 1'b1;
            @(negedge clk); @(negedge clk);
            rd((p < 32) ? 8'h40 : 8'h44, v0);
            check("R3 not yet after two edges", v0, 0);
            @(negedge clk);
            rd(8'h40, v0); check("R3 status0 on third edge", v0, e0);
            rd(8'h44, v1); check("R3 status1 on third edge", v1, e1);
            check("R12 irq group", 32'(irq), 32'(ei));
            @(negedge clk);
            wr((p < 32) ? 8'h40 : 8'h44, (p < 32) ? e0 : e1);
            pins[p] = 1'b0;
            repeat (4) @(negedge clk);
            rd(8'h40, v0); check("R13 fall ignored with rise only", v0, 0);
            rd(8'h44, v1); check("R13 fall ignored with rise only", v1, 0);
            check("R12 irq low after clear", 32'(irq), 0);
        end
        wr(8'h4C, 0);
        wr(8'h50, 0);

        // R4 falling edge on pin 5
        wr(8'h58, 32'd1 << 5);
        pins[5] = 1'b1;
        repeat (4) @(negedge clk);
        rd(8'h40, v0); check("R4 rise ignored with fall only", v0, 0);
        pins[5] = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h40, v0); check("R4 fall detected", v0, 32'd1 << 5);
        wr(8'h58, 0);
        clear_all();

        // R5 both edges on pin 40 (bank1 bit 8)
        wr(8'h50, 32'd1 << 8);
        wr(8'h5C, 32'd1 << 8);
        pins[40] = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h44, v1); check("R5 rising with both", v1, 32'd1 << 8);
        check("R12 pin40 on irq1", 32'(irq), 32'b010);
        wr(8'h44, 32'd1 << 8);
        pins[40] = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h44, v1); check("R5 falling with both", v1, 32'd1 << 8);
        wr(8'h50, 0);
        wr(8'h5C, 0);
        clear_all();

        // R6 high level on pin 50 (bank1 bit 18)
        wr(8'h68, 32'd1 << 18);
        pins[50] = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h44, v1); check("R6 high level set", v1, 32'd1 << 18);
        check("R12 pin50 on irq2", 32'(irq), 32'b100);
        wr(8'h44, 32'd1 << 18);
        rd(8'h44, v1); check("R6 clear lost while level holds", v1, 32'd1 << 18);
        pins[50] = 1'b0;
        repeat (3) @(negedge clk);
        wr(8'h44, 32'd1 << 18);
        rd(8'h44, v1); check("R6 clear after level gone", v1, 0);
        wr(8'h68, 0);

        // R7 low level on pin 3, R10 sticky after disable
        wr(8'h70, 32'd1 << 3);
        @(negedge clk);
        rd(8'h40, v0); check("R7 low level set", v0, 32'd1 << 3);
        wr(8'h70, 0);
        @(negedge clk);
        rd(8'h40, v0); check("R10 sticky after disable", v0, 32'd1 << 3);
        wr(8'h40, 32'd1 << 3);
        rd(8'h40, v0); check("R10 clear by write", v0, 0);

        // R8 early rise on pin 10
        wr(8'h7C, 32'd1 << 10);
        pins[10] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(8'h40, v0); check("R8 early rise on second edge", v0, 32'd1 << 10);
        wr(8'h7C, 0);
        clear_all();
        pins[10] = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h40, v0); check("R13 no enable no status", v0, 0);

        // R8 early fall on pin 33 (bank1 bit 1)
        pins[33] = 1'b1;
        repeat (3) @(negedge clk);
        wr(8'h8C, 32'd1 << 1);
        pins[33] = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(8'h44, v1); check("R8 early fall on second edge", v1, 32'd2);
        wr(8'h8C, 0);
        clear_all();

        // R9 W1C selective
        wr(8'h4C, 32'd7);
        pins[2:0] = 3'b111;
        repeat (3) @(negedge clk);
        rd(8'h40, v0); check("R9 three set", v0, 32'd7);
        wr(8'h40, 0);
        rd(8'h40, v0); check("R9 zero write no effect", v0, 32'd7);
        wr(8'h40, 32'd2);
        rd(8'h40, v0); check("R9 clear bit1 only", v0, 32'd5);
        wr(8'h40, 32'd5);
        rd(8'h40, v0); check("R9 clear rest", v0, 0);
        wr(8'h4C, 0);
        pins[2:0] = 3'b000;
        repeat (3) @(negedge clk);

        // R11 event and clear on same edge, pin 7
        wr(8'h4C, 32'd1 << 7);
        wr(8'h58, 32'd1 << 7);
        pins[7] = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h40, v0); check("R11 setup", v0, 32'd1 << 7);
        pins[7] = 1'b0;
        @(negedge clk); @(negedge clk);
        wr(8'h40, 32'd1 << 7);
        rd(8'h40, v0); check("R11 event wins over clear", v0, 32'd1 << 7);
        wr(8'h40, 32'd1 << 7);
        rd(8'h40, v0); check("R11 later clear works", v0, 0);
        check("R12 all irq low", 32'(irq), 0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule